// File: doc/BRIEF.md
# Seven-to-one display link serializer

This block turns a wide parallel pixel word into five serial lanes for a display cable. Each pixel period it takes one 28-bit word (three 8-bit colour channels, horizontal sync, vertical sync, data enable and one spare control bit) from the falling edge of the pixel clock. It sends that word as seven bits on each of four data lanes and drives a fifth lane with a seven-bit pattern that lets the receiver recover the pixel clock. A free-running bit clock at seven times the pixel rate is an input, so no frequency synthesis is modelled. The lane outputs are single-ended bits for differential pad drivers placed downstream.

An active-low power-down input holds every register in reset and drops the output enable, so the pad drivers go to high impedance. A monitor in the bit-clock domain watches for pixel-clock falling edges. When none arrive for sixteen bit clocks it forces all five lanes low. When edges come back it restores output by itself at a frame boundary, so the clock can stop and restart with power-down left high.

Top module: `ser7_link_tx`

## Requirements
- R1: The word sent in a frame is the value `pix_word` held at a falling edge of `pix_clk`. Input changes away from that edge do not affect the frame.
- R2: Data lane k carries input bits 7k to 7k+6, with bit 7k+s in slot s. Slot 0 goes out first.
- R3: In normal operation the clock lane sends 1,1,0,0,0,1,1 in slots 0 to 6 of every frame.
- R4: Every captured word is sent exactly once and in capture order. When a frame finishes, no more than three words captured after it are waiting.
- R5: While `pd_n` is low, `lane_oe` is low and all data lanes and the clock lane are low.
- R6: With `pd_n` high and no `pix_clk` falling edge for 16 bit clocks, all four data lanes and the clock lane are driven low while `lane_oe` stays high.
- R7: After pixel-clock loss, output resumes with no power-down cycle. It waits for two pixel-clock falling edges with no new loss, then starts at a slot-0 boundary with a complete frame. Output stays low for at least the first nine bit clocks after the clock restarts.
- R8: Frames are exactly seven bit clocks long and follow each other with no gap. The slot index advances by one every bit clock.
- R9: The pixel clock may already run when `pd_n` is released, or may start later. Either way the link comes up with no other action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Free-running serial bit clock, seven times the pixel rate |
| pix_clk | input | 1 | Pixel clock; its falling edge captures the word |
| pd_n | input | 1 | Active-low power-down and asynchronous reset |
| pix_word | input | 28 | Parallel pixel word: colour, sync, enable and spare bits |
| lane_data | output | 4 | Serial data lanes, one bit per bit clock |
| lane_clk | output | 1 | Serial clock-pattern lane |
| lane_oe | output | 1 | Pad driver enable; low means high impedance |

## Verification
A counter-derived word sequence with a distinct value in every pixel period exercises ordering and latency, and it lets the bench find its place again after every restart. A walking-one word shows whether any bit lands on the wrong lane or in the wrong slot. Alternating 0x5555555/0xAAAAAAA words and alternating all-ones/all-zeros words catch swapped neighbouring slots, and stale data held over between frames. Three disturbances test the loss monitor and the power-down path, each with its own recovery: a stopped pixel clock, power-down asserted while the clock runs, and power-down released while the clock is still stopped.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

    // Bit slots per pixel period on every lane; the framing depends on it.
    localparam int unsigned SLOTS = 7;

    // Clock-lane pattern, bit s is sent in slot s: 1,1,0,0,0,1,1.
    localparam logic [SLOTS-1:0] CLK_LANE_PAT = 7'b1100011;

    typedef enum logic {
        LINK_RUN   = 1'b0,
        LINK_MUTED = 1'b1
    } link_state_e;

endpackage

// File: rtl/ser7_pix_capture.sv
module ser7_pix_capture #(
    parameter int unsigned W = 28
) (
    input  logic         pix_clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] word_o,
    output logic         flag_o
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         flag;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.word = din;
        cap_d.flag = ~cap_q.flag;
    end

    always_ff @(negedge pix_clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign word_o = cap_q.word;
    assign flag_o = cap_q.flag;

endmodule

// File: rtl/ser7_word_sync.sv
module ser7_word_sync #(
    parameter int unsigned W = 28
) (
    input  logic         bit_clk,
    input  logic         rst_n,
    input  logic         flag_i,
    input  logic [W-1:0] word_i,
    output logic         new_o,
    output logic [W-1:0] word_o
);

    typedef struct packed {
        logic [2:0]   sync;
        logic [W-1:0] hold;
    } sync_t;

    sync_t sy_d, sy_q;
    logic  arrive;

    // stage 1 and 2 resynchronise the toggle, stage 3 is the edge reference
    assign arrive = sy_q.sync[1] ^ sy_q.sync[2];

    always_comb begin
        sy_d      = sy_q;
        sy_d.sync = {sy_q.sync[1:0], flag_i};
        if (arrive) begin
            sy_d.hold = word_i;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign new_o  = arrive;
    assign word_o = sy_q.hold;

endmodule

// File: rtl/ser7_clk_monitor.sv
module ser7_clk_monitor
    import ser7_pkg::*;
#(
    parameter int unsigned LOSS_LIMIT   = 16,
    parameter int unsigned GOOD_PERIODS = 2
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic seen_i,
    input  logic frame_end_i,
    output logic mute_o
);

    localparam int unsigned MISS_W = $clog2(LOSS_LIMIT + 1);
    localparam int unsigned GOOD_W = $clog2(GOOD_PERIODS + 1);

    typedef struct packed {
        logic [MISS_W-1:0] miss;
        logic [GOOD_W-1:0] good;
        link_state_e       st;
    } mon_t;

    localparam mon_t MON_RST = '{miss: '0, good: '0, st: LINK_MUTED};

    mon_t mon_d, mon_q;
    logic lost;

    assign lost = !seen_i && (mon_q.miss >= MISS_W'(LOSS_LIMIT - 1));

    always_comb begin
        mon_d = mon_q;
        if (seen_i) begin
            mon_d.miss = '0;
        end else if (!lost) begin
            mon_d.miss = mon_q.miss + 1'b1;
        end
        if (seen_i && (mon_q.good < GOOD_W'(GOOD_PERIODS))) begin
            mon_d.good = mon_q.good + 1'b1;
        end
        if ((mon_q.st == LINK_MUTED) && (mon_q.good == GOOD_W'(GOOD_PERIODS)) && frame_end_i) begin
            mon_d.st = LINK_RUN;
        end
        if (lost) begin
            mon_d.st   = LINK_MUTED;
            mon_d.good = '0;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= MON_RST;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign mute_o = (mon_q.st == LINK_MUTED);

endmodule

// File: rtl/ser7_lane_shift.sv
module ser7_lane_shift
    import ser7_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                     bit_clk,
    input  logic                     rst_n,
    input  logic [LANES*SLOTS-1:0]   word_i,
    input  logic                     mute_i,
    output logic [LANES-1:0]         lanes_o,
    output logic                     clk_lane_o,
    output logic                     frame_end_o,
    output logic [$clog2(SLOTS)-1:0] slot_o
);

    localparam int unsigned SLOT_W = $clog2(SLOTS);

    typedef struct packed {
        logic [SLOT_W-1:0]           slot;
        logic [LANES-1:0][SLOTS-1:0] sh;
        logic [SLOTS-1:0]            ck;
        logic [LANES-1:0]            dout;
        logic                        cout;
    } shf_t;

    localparam shf_t SHF_RST = '{slot: '0, sh: '0, ck: CLK_LANE_PAT, dout: '0, cout: 1'b0};

    logic [LANES-1:0][SLOTS-1:0] chunk;
    shf_t sf_d, sf_q;
    logic last;

    for (genvar k = 0; k < LANES; k++) begin : g_chunk
        assign chunk[k] = word_i[k*SLOTS +: SLOTS];
    end

    assign last = (sf_q.slot == SLOT_W'(SLOTS - 1));

    always_comb begin
        sf_d = sf_q;
        if (last) begin
            sf_d.slot = '0;
            sf_d.sh   = chunk;
            sf_d.ck   = CLK_LANE_PAT;
        end else begin
            sf_d.slot = sf_q.slot + 1'b1;
            for (int k = 0; k < LANES; k++) begin
                sf_d.sh[k] = sf_q.sh[k] >> 1;
            end
            sf_d.ck = sf_q.ck >> 1;
        end
        for (int k = 0; k < LANES; k++) begin
            sf_d.dout[k] = !mute_i && sf_q.sh[k][0];
        end
        sf_d.cout = !mute_i && sf_q.ck[0];
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            sf_q <= SHF_RST;
        end else begin
            sf_q <= sf_d;
        end
    end

    assign lanes_o     = sf_q.dout;
    assign clk_lane_o  = sf_q.cout;
    assign frame_end_o = last;
    assign slot_o      = sf_q.slot;

endmodule

// File: rtl/ser7_link_tx.sv
module ser7_link_tx
    import ser7_pkg::*;
#(
    parameter int unsigned LANES        = 4,
    parameter int unsigned LOSS_LIMIT   = 16,
    parameter int unsigned GOOD_PERIODS = 2
) (
    input  logic                   bit_clk,
    input  logic                   pix_clk,
    input  logic                   pd_n,
    input  logic [LANES*SLOTS-1:0] pix_word,
    output logic [LANES-1:0]       lane_data,
    output logic                   lane_clk,
    output logic                   lane_oe
);

    localparam int unsigned WORD_W = LANES * SLOTS;
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    logic [WORD_W-1:0] cap_word;
    logic              cap_flag;
    logic [WORD_W-1:0] held_word;
    logic              seen_w;
    logic              mute_w;
    logic              frame_end_w;
    logic [SLOT_W-1:0] slot_w;

    ser7_pix_capture #(.W(WORD_W)) u_cap (
        .pix_clk (pix_clk),
        .rst_n   (pd_n),
        .din     (pix_word),
        .word_o  (cap_word),
        .flag_o  (cap_flag)
    );

    ser7_word_sync #(.W(WORD_W)) u_sync (
        .bit_clk (bit_clk),
        .rst_n   (pd_n),
        .flag_i  (cap_flag),
        .word_i  (cap_word),
        .new_o   (seen_w),
        .word_o  (held_word)
    );

    ser7_clk_monitor #(
        .LOSS_LIMIT   (LOSS_LIMIT),
        .GOOD_PERIODS (GOOD_PERIODS)
    ) u_mon (
        .bit_clk     (bit_clk),
        .rst_n       (pd_n),
        .seen_i      (seen_w),
        .frame_end_i (frame_end_w),
        .mute_o      (mute_w)
    );

    ser7_lane_shift #(.LANES(LANES)) u_shf (
        .bit_clk     (bit_clk),
        .rst_n       (pd_n),
        .word_i      (held_word),
        .mute_i      (mute_w),
        .lanes_o     (lane_data),
        .clk_lane_o  (lane_clk),
        .frame_end_o (frame_end_w),
        .slot_o      (slot_w)
    );

    // pad drivers are released to high impedance while powered down
    assign lane_oe = pd_n;

endmodule

// File: rtl/ser7_link_tx_chk.sv
module ser7_link_tx_chk
    import ser7_pkg::*;
#(
    parameter int unsigned LANES      = 4,
    parameter int unsigned LOSS_LIMIT = 16
) (
    input logic                     bit_clk,
    input logic                     pd_n,
    input logic [LANES-1:0]         lane_data,
    input logic                     lane_clk,
    input logic                     mute,
    input logic                     seen,
    input logic [$clog2(SLOTS)-1:0] slot
);

    localparam int unsigned GAP_W = $clog2(LOSS_LIMIT + 1);

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge bit_clk or negedge pd_n) begin
        if (!pd_n) begin
            gap_q <= '0;
        end else if (seen) begin
            gap_q <= '0;
        end else if (gap_q < GAP_W'(LOSS_LIMIT)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_MUTED_LANES_LOW: assert property (@(posedge bit_clk) disable iff (!pd_n)
        mute |=> (lane_data == '0) && !lane_clk);                            // R6

    AST_GAP_FORCES_MUTE: assert property (@(posedge bit_clk) disable iff (!pd_n)
        (gap_q == GAP_W'(LOSS_LIMIT)) |-> mute);                             // R6

    AST_CLK_SLOT0_HIGH: assert property (@(posedge bit_clk) disable iff (!pd_n)
        (!mute && slot == '0) |=> lane_clk);                                 // R3

    AST_CLK_SLOT3_LOW: assert property (@(posedge bit_clk) disable iff (!pd_n)
        (!mute && slot == 3'd3) |=> !lane_clk);                              // R3

    AST_RESUME_AT_SLOT0: assert property (@(posedge bit_clk) disable iff (!pd_n)
        $fell(mute) |-> (slot == '0));                                       // R7

    AST_SLOT_ADVANCE: assert property (@(posedge bit_clk) disable iff (!pd_n)
        (slot != 3'(SLOTS - 1)) |=> (slot == $past(slot) + 1'b1));           // R8

    AST_SLOT_WRAP: assert property (@(posedge bit_clk) disable iff (!pd_n)
        (slot == 3'(SLOTS - 1)) |=> (slot == '0));                           // R8

endmodule

bind ser7_link_tx ser7_link_tx_chk #(
    .LANES      (LANES),
    .LOSS_LIMIT (LOSS_LIMIT)
) u_chk (
    .bit_clk   (bit_clk),
    .pd_n      (pd_n),
    .lane_data (lane_data),
    .lane_clk  (lane_clk),
    .mute      (mute_w),
    .seen      (seen_w),
    .slot      (slot_w)
);

// File: tb/ser7_link_tx_bench.sv
module ser7_link_tx_bench;

    localparam int LN = 4;
    localparam int WW = 28;
    localparam logic [6:0] PAT = 7'b1100011;

    logic          bit_clk = 1'b0;
    logic          pix_clk = 1'b0;
    logic          pd_n    = 1'b0;
    logic [WW-1:0] pix_word = '0;
    logic [LN-1:0] lane_data;
    logic          lane_clk;
    logic          lane_oe;

    int errors = 0;
    int checks = 0;
    int decoded = 0;
    int seq = 0;
    int mode = 0;
    int phase = 0;
    bit pix_run = 1'b1;
    bit draining = 1'b1;
    bit resync = 1'b1;
    bit chk_zero = 1'b0;
    bit locked = 1'b0;
    bit finished = 1'b0;

    logic [WW-1:0] q[$];
    logic [6:0]    hd[LN];
    logic [6:0]    hc = '0;

    ser7_link_tx u_ser7_link_tx (
        .bit_clk   (bit_clk),
        .pix_clk   (pix_clk),
        .pd_n      (pd_n),
        .pix_word  (pix_word),
        .lane_data (lane_data),
        .lane_clk  (lane_clk),
        .lane_oe   (lane_oe)
    );

    always #10 bit_clk = ~bit_clk;

    initial begin
        #3;
        forever begin
            if (pix_run) begin
                pix_clk = 1'b1;
                #70;
                pix_clk = 1'b0;
                #70;
            end else begin
                #20;
            end
        end
    end

    function automatic logic [WW-1:0] gen(int m, int s);
        case (m)
            0:       gen = 28'(s * 32'h0019_660D + 32'h3C6E_F35F);
            1:       gen = 28'h1 << (s % 28);
            2:       gen = (s % 2 != 0) ? 28'h5555555 : 28'hAAAAAAA;
            default: gen = (s % 2 != 0) ? 28'hFFFFFFF : 28'h0000000;
        endcase
    endfunction

    // word changes on the rising edge, mid-way between capture edges (R1)
    always @(posedge pix_clk) begin
        pix_word <= gen(mode, seq);
        seq      <= seq + 1;
    end

    always @(negedge pix_clk) begin
        if (pd_n) q.push_back(pix_word);
    end

    task automatic fail(string req, string what);
        errors++;
        $display("FAIL %s: %s", req, what);
    endtask

    task automatic wait_bits(int n);
        repeat (n) @(posedge bit_clk);
        #3;
    endtask

    task automatic expect_min(string req, int got, int lo);
        checks++;
        if (got < lo) fail(req, $sformatf("frames actual=%0d expected>=%0d", got, lo));
    endtask

    always @(negedge bit_clk) begin
        if (!pd_n) begin
            // R5: powered down, drivers off and lanes low
            checks++;
            if (lane_oe !== 1'b0 || lane_data !== '0 || lane_clk !== 1'b0)
                fail("R5", $sformatf("oe/data/clk actual=%b/%h/%b expected=0/0/0",
                                     lane_oe, lane_data, lane_clk));
            locked = 1'b0;
        end else begin
            if (chk_zero) begin
                checks++;
                if (lane_data !== '0 || lane_clk !== 1'b0 || lane_oe !== 1'b1)
                    fail("R6", $sformatf("oe/data/clk actual=%b/%h/%b expected=1/0/0",
                                         lane_oe, lane_data, lane_clk));
            end
            if (draining) begin
                locked = 1'b0;
                hc = '0;
                for (int k = 0; k < LN; k++) hd[k] = '0;
            end else begin
                if (locked) begin
                    checks++;
                    if (lane_clk !== PAT[phase])
                        fail("R3", $sformatf("clock lane slot %0d actual=%b expected=%b",
                                             phase, lane_clk, PAT[phase]));
                    phase = (phase + 1) % 7;
                end
                hc = {hc[5:0], lane_clk};
                for (int k = 0; k < LN; k++) hd[k] = {hd[k][5:0], lane_data[k]};
                if (hc == PAT) begin
                    logic [WW-1:0] w;
                    if (locked) begin
                        checks++;
                        if (phase != 0) fail("R8", $sformatf("frame end at slot actual=%0d expected=0", phase));
                    end
                    locked = 1'b1;
                    phase = 0;
                    for (int k = 0; k < LN; k++)
                        for (int s = 0; s < 7; s++)
                            w[7*k+s] = hd[k][6-s];
                    decoded++;
                    checks++;
                    if (resync) begin
                        int idx;
                        idx = -1;
                        foreach (q[i]) if (idx < 0 && q[i] == w) idx = i;
                        if (idx < 0) fail("R7", $sformatf("first frame actual=%h expected a captured word", w));
                        else begin
                            repeat (idx + 1) void'(q.pop_front());
                            resync = 1'b0;
                        end
                    end else if (q.size() == 0) begin
                        fail("R4", $sformatf("frame actual=%h expected none pending", w));
                    end else begin
                        logic [WW-1:0] exp_w;
                        exp_w = q.pop_front();
                        if (w !== exp_w) fail("R1/R2", $sformatf("word actual=%h expected=%h", w, exp_w));
                        checks++;
                        if (q.size() > 3) fail("R4", $sformatf("backlog actual=%0d expected<=3", q.size()));
                    end
                end
            end
        end
    end

    initial begin
        int f;
        for (int k = 0; k < LN; k++) hd[k] = '0;
        // R9: clock already running while powered down
        pd_n = 1'b0; pix_run = 1'b1; mode = 0;
        wait_bits(40);
        q.delete(); resync = 1'b1; draining = 1'b0; pd_n = 1'b1;
        f = decoded;
        wait_bits(60 * 7);
        mode = 1; wait_bits(30 * 7);
        mode = 2; wait_bits(30 * 7);
        mode = 3; wait_bits(30 * 7);
        mode = 0; wait_bits(10 * 7);
        expect_min("R4", decoded - f, 150);

        // R6: pixel clock stops, lanes forced low
        draining = 1'b1; pix_run = 1'b0;
        wait_bits(40);
        chk_zero = 1'b1; wait_bits(20); chk_zero = 1'b0;

        // R7: restart with no power-down cycle
        q.delete(); resync = 1'b1; draining = 1'b0; pix_run = 1'b1;
        chk_zero = 1'b1; wait_bits(9); chk_zero = 1'b0;
        f = decoded;
        wait_bits(60 * 7);
        expect_min("R7", decoded - f, 50);

        // R5: power-down while the clock runs
        pd_n = 1'b0; wait_bits(20);
        q.delete(); resync = 1'b1; pd_n = 1'b1;
        f = decoded;
        wait_bits(40 * 7);
        expect_min("R9", decoded - f, 30);

        // R9: release power-down while the clock is stopped, start it later
        pd_n = 1'b0; draining = 1'b1; pix_run = 1'b0;
        wait_bits(20);
        pd_n = 1'b1;
        chk_zero = 1'b1; wait_bits(30); chk_zero = 1'b0;
        q.delete(); resync = 1'b1; draining = 1'b0; pix_run = 1'b1;
        f = decoded;
        wait_bits(40 * 7);
        expect_min("R9", decoded - f, 30);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule